// File: doc/BRIEF.md
# Depth-Expansion FIFO Slice Chain

A synchronous FIFO built from identical slices joined in a ring so that the ring acts as one deep buffer. Every slice sees the same write strobe, write data, read strobe and clock. Two tokens decide which slice acts on them. The write token marks the slice that stores the next incoming word. The read token marks the slice that holds the oldest word and drives the shared read port. A token leaves a slice when that slice's write or read pointer steps past its last location. A one-cycle pulse on the expansion link carries it to the next slice in the ring, and the last slice links back to the first.

Each slice has a first-load input (active low) that marks the slice owning both tokens after reset. It also has a two-wire expansion input from the previous slice and a two-wire expansion output to the next. Wire `wr` carries the write hand-off and wire `rd` carries the read hand-off. When the chain has one slice, that slice runs in single-device mode: it keeps both tokens for good and ignores its expansion input. Its expansion `wr` wire then carries a half-full indication. The wrapper builds the composite flags from each slice's active-low full and empty flags. Each composite flag is the OR of those active-low flags, so it asserts only when every slice asserts it.

Top module: `fifo_depth_chain`

## Requirements
- R1: After reset release, `empty_o`=1, `full_o`=0, `rd_valid_o`=0 and `half_o`=0.
- R2: With NUM_SLICES=1 the block is a standalone FIFO of SLICE_DEPTH words. It has first-in/first-out order and its full and empty flags work, with no token hand-off.
- R3: With NUM_SLICES=1, `half_o` is 1 exactly when occupancy exceeds SLICE_DEPTH/2.
- R4: After reset the slice with first-load low (slice 0) accepts the first write and supplies the first read.
- R5: A write into the last location of the write-token holder passes the write token to the next slice through a one-cycle pulse. A write in the pulse cycle is accepted by the receiving slice. No write is lost or duplicated.
- R6: A read from the last location of the read-token holder passes the read token to the next slice in the same way. The read order continues with no gap.
- R7: `full_o` is 1 exactly when all NUM_SLICES*SLICE_DEPTH words are occupied. A write strobe while full is ignored.
- R8: `empty_o` is 1 exactly when no word is stored. A read strobe while empty is ignored.
- R9: `rd_valid_o` equals not-empty, and `rd_data_o` shows the oldest stored word (show-ahead). Only the read-token holder drives them.
- R10: A read and a write strobe in the same cycle are each accepted according to the state before the edge. At full the read is taken and the write is dropped. At empty the write is taken and the read is dropped.
- R11: With NUM_SLICES>1, `half_o` stays 0.
- R12: Over long mixed traffic both tokens wrap around the ring many times, and the chain stays equal to one queue of depth NUM_SLICES*SLICE_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one word per cycle |
| wr_data_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe, pops the head word |
| rd_data_o | output | DATA_W | Oldest stored word (show-ahead) |
| rd_valid_o | output | 1 | Head word present |
| full_o | output | 1 | Composite full |
| empty_o | output | 1 | Composite empty |
| half_o | output | 1 | Half-full in single-slice mode, else 0 |

## Verification
A token that is lost, duplicated or moved at the wrong pointer value reorders the data. The first read after the faulty hand-off then shows the wrong word on `rd_data_o`, or a dropped word, or a valid head while the reference is empty. This appears within one slice depth of reads. A wrong occupancy count in any slice changes the composite full or empty flag in the cycle it diverges, because every slice takes part in that flag. The bench compares flags, valid and head data against a behavioural queue after every clock. It drives fills and drains that cross every slice boundary, plus long mixed traffic that wraps both tokens.

// File: rtl/fifo_exp_pkg.sv
`timescale 1ns/1ps
package fifo_exp_pkg;
  // Two-wire expansion link between neighbouring slices.
  typedef struct packed {
    logic rd;
    logic wr;
  } exp_link_t;
endpackage

// File: rtl/exp_token_ptr.sv
`timescale 1ns/1ps
module exp_token_ptr #(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          solo_i,
  input  logic          first_i,
  input  logic          step_i,
  input  logic          pass_i,
  output logic [AW-1:0] ptr_o,
  output logic          tok_o,
  output logic          pulse_o
);
  logic [AW-1:0] ptr_q;
  logic          tok_q;
  logic          pulse_q;
  logic          at_last;
  logic          handoff;

  assign at_last = (ptr_q == AW'(DEPTH - 1));
  // the receiving slice owns the token already in the pulse cycle
  assign tok_o   = solo_i | tok_q | pass_i;
  assign handoff = step_i & at_last & ~solo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      tok_q   <= first_i;
      pulse_q <= 1'b0;
    end else begin
      if (step_i) ptr_q <= at_last ? '0 : ptr_q + AW'(1);
      tok_q   <= handoff ? 1'b0 : (tok_q | pass_i);
      pulse_q <= handoff;
    end
  end

  assign ptr_o   = ptr_q;
  assign pulse_o = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q); // R5
  AST_HANDOFF_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> !tok_q); // R6
endmodule

// File: rtl/slice_mem.sv
`timescale 1ns/1ps
module slice_mem #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/fifo_slice.sv
`timescale 1ns/1ps
module fifo_slice
  import fifo_exp_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              solo_i,
  input  logic              first_load_ni,
  input  exp_link_t         xi_i,
  output exp_link_t         xo_o,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              full_no,
  output logic              empty_no,
  output logic              wr_tok_o,
  output logic              rd_tok_o
);
  logic [CW-1:0]     count_q;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              wr_tok, rd_tok;
  logic              wr_pulse, rd_pulse;
  logic              full, empty, half;
  logic              wr_acc, rd_acc;
  logic              first;
  logic [DATA_W-1:0] head;

  assign first  = ~first_load_ni & ~solo_i;
  assign full   = (count_q == CW'(DEPTH));
  assign empty  = (count_q == '0);
  assign half   = (count_q > CW'(DEPTH / 2));
  assign wr_acc = wr_i & wr_tok & ~full;
  assign rd_acc = rd_i & rd_tok & ~empty;

  exp_token_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .solo_i  (solo_i),
    .first_i (first),
    .step_i  (wr_acc),
    .pass_i  (xi_i.wr & ~solo_i),
    .ptr_o   (wr_ptr),
    .tok_o   (wr_tok),
    .pulse_o (wr_pulse)
  );

  exp_token_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .solo_i  (solo_i),
    .first_i (first),
    .step_i  (rd_acc),
    .pass_i  (xi_i.rd & ~solo_i),
    .ptr_o   (rd_ptr),
    .tok_o   (rd_tok),
    .pulse_o (rd_pulse)
  );

  slice_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_acc),
    .wr_addr_i (wr_ptr),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_ptr),
    .rd_data_o (head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (wr_acc && !rd_acc) count_q <= count_q + CW'(1);
    else if (rd_acc && !wr_acc) count_q <= count_q - CW'(1);
  end

  // single-device mode: expansion out carries half-full
  always_comb begin
    if (solo_i) begin
      xo_o.rd = 1'b0;
      xo_o.wr = half;
    end else begin
      xo_o.rd = rd_pulse;
      xo_o.wr = wr_pulse;
    end
  end

  assign rd_valid_o = rd_tok & ~empty;
  assign rd_data_o  = rd_valid_o ? head : '0;
  assign full_no    = ~full;
  assign empty_no   = ~empty;
  assign wr_tok_o   = wr_tok;
  assign rd_tok_o   = rd_tok;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R7
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |=> $stable(rd_ptr)); // R8
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CW'(DEPTH)) |=> $stable(wr_ptr)); // R7
endmodule

// File: rtl/fifo_depth_chain.sv
`timescale 1ns/1ps
module fifo_depth_chain
  import fifo_exp_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int SLICE_DEPTH = 4,
  parameter int NUM_SLICES  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              half_o
);
  localparam logic SOLO = (NUM_SLICES == 1);

  exp_link_t         link   [NUM_SLICES];
  logic [DATA_W-1:0] s_data [NUM_SLICES];
  logic [NUM_SLICES-1:0] s_valid, s_full_n, s_empty_n, s_wr_tok, s_rd_tok;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    fifo_slice #(.DATA_W(DATA_W), .DEPTH(SLICE_DEPTH)) u_slice (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .solo_i        (SOLO),
      .first_load_ni ((g == 0) ? 1'b0 : 1'b1),
      .xi_i          (link[(g + NUM_SLICES - 1) % NUM_SLICES]),
      .xo_o          (link[g]),
      .wr_i          (wr_i),
      .wr_data_i     (wr_data_i),
      .rd_i          (rd_i),
      .rd_data_o     (s_data[g]),
      .rd_valid_o    (s_valid[g]),
      .full_no       (s_full_n[g]),
      .empty_no      (s_empty_n[g]),
      .wr_tok_o      (s_wr_tok[g]),
      .rd_tok_o      (s_rd_tok[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_SLICES; i++) rd_data_o |= s_data[i];
  end

  assign rd_valid_o = |s_valid;
  // active-low OR: composite asserts only when all slices assert
  assign full_o  = ~(|s_full_n);
  assign empty_o = ~(|s_empty_n);
  assign half_o  = SOLO ? link[0].wr : 1'b0;

  AST_ONE_WRITE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(s_wr_tok) == 1); // R5
  AST_ONE_READ_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(s_rd_tok) == 1); // R9
  AST_SINGLE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_valid)); // R9
  AST_VALID_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o != empty_o); // R9
endmodule

// File: tb/tb_fifo_depth_chain.sv
`timescale 1ns/1ps
module tb_fifo_depth_chain;
  localparam int DW  = 9;
  localparam int D   = 4;
  localparam int N   = 3;
  localparam int CAP = D * N;
  localparam int SD  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;

  logic [DW-1:0] e_data, s_data;
  logic e_valid, e_full, e_empty, e_half;
  logic s_valid, s_full, s_empty, s_half;

  int checks = 0;
  int fails  = 0;
  int q_e[$];
  int q_s[$];

  always #2.5 clk = ~clk;

  fifo_depth_chain #(.DATA_W(DW), .SLICE_DEPTH(D), .NUM_SLICES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdata), .rd_i(rd),
    .rd_data_o(e_data), .rd_valid_o(e_valid), .full_o(e_full),
    .empty_o(e_empty), .half_o(e_half)
  );

  fifo_depth_chain #(.DATA_W(DW), .SLICE_DEPTH(SD), .NUM_SLICES(1)) dut_solo (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdata), .rd_i(rd),
    .rd_data_o(s_data), .rd_valid_o(s_valid), .full_o(s_full),
    .empty_o(s_empty), .half_o(s_half)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk("R7", "chain full", int'(e_full), int'(q_e.size() == CAP));
    chk("R8", "chain empty", int'(e_empty), int'(q_e.size() == 0));
    chk("R9", "chain valid", int'(e_valid), int'(q_e.size() != 0));
    if (q_e.size() != 0) chk(tag, "chain head", int'(e_data), q_e[0]);
    chk("R11", "chain half", int'(e_half), 0);
    chk("R2", "solo full", int'(s_full), int'(q_s.size() == SD));
    chk("R2", "solo empty", int'(s_empty), int'(q_s.size() == 0));
    if (q_s.size() != 0) chk("R2", "solo head", int'(s_data), q_s[0]);
    chk("R3", "solo half", int'(s_half), int'(q_s.size() > SD / 2));
  endtask

  task automatic step(bit w, bit r, string tag);
    bit pe, we, ps, ws;
    @(negedge clk);
    compare(tag);
    wr = w;
    rd = r;
    wdata = DW'($urandom);
    @(posedge clk);
    pe = r && q_e.size() > 0;
    we = w && q_e.size() < CAP;
    ps = r && q_s.size() > 0;
    ws = w && q_s.size() < SD;
    if (pe) void'(q_e.pop_front());
    if (we) q_e.push_back(int'(wdata));
    if (ps) void'(q_s.pop_front());
    if (ws) q_s.push_back(int'(wdata));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "empty", int'(e_empty), 1);
    chk("R1", "full", int'(e_full), 0);
    chk("R1", "valid", int'(e_valid), 0);
    chk("R1", "half", int'(s_half), 0);
    chk("R1", "solo empty", int'(s_empty), 1);
    // R4 first slice owns both tokens
    step(1, 0, "R4");
    step(0, 0, "R4");
    step(0, 1, "R4");
    step(0, 0, "R4");
    // R5 back-to-back writes crossing every slice boundary
    for (int i = 0; i < CAP; i++) step(1, 0, "R5");
    // R7 writes while full are dropped
    for (int i = 0; i < 3; i++) step(1, 0, "R7");
    step(0, 0, "R7");
    // R10 at full: read taken, write dropped
    step(1, 1, "R10");
    step(1, 0, "R10");
    // R6 back-to-back reads crossing every slice boundary
    for (int i = 0; i < CAP; i++) step(0, 1, "R6");
    // R8 reads while empty are dropped
    for (int i = 0; i < 3; i++) step(0, 1, "R8");
    // R10 at empty: write taken, read dropped
    step(1, 1, "R10");
    step(0, 0, "R10");
    // R12 long mixed traffic wrapping both tokens
    for (int blk = 0; blk < 24; blk++) begin
      int pw;
      pw = (blk % 3 == 0) ? 80 : ((blk % 3 == 1) ? 50 : 25);
      for (int i = 0; i < 200; i++)
        step(($urandom % 100) < pw, ($urandom % 100) < (100 - pw + 10), "R12");
    end
    for (int i = 0; i < CAP + 2; i++) step(0, 1, "R12");
    step(0, 0, "R12");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule